// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master. From four static configuration
words it builds the SCL waveform and tells the byte engine above it exactly when
SDA may change and when SDA should be read. It pulls SCL low for one half of the
period and releases it for the other half. It counts the released half only in
cycles where the line actually reads high, so a slave that holds SCL low
stretches the clock.

The engine controls the block with a single `run` level. When `run` is high, the
block cycles through low and high halves. When `run` is low, it parks with SCL
released, and every counter and flag is cleared. Each time SCL falls, a launch
strobe fires after a programmable number of core cycles. Each time the line is
seen high, a sample strobe fires after a second programmable delay. If a slave
stretches for longer than a programmable number of SCL periods, the block raises
a timeout flag, stops toggling, and waits for the engine to drop `run`.

The `scl_in` input must already be synchronised to `clk`. The block adds no
synchroniser of its own, so detection latency does not lengthen the period.

Top module: `i2c_scl_timer`

## Requirements
- R1: The effective divider is `cfg_div` with bit 0 forced to 0. Without stretching, SCL is driven low for exactly half the effective divider and released for exactly half, so a full period lasts the effective divider in core cycles (for example, 8 and 9 both give 4 low and 4 released cycles).
- R2: An effective divider of 0 (`cfg_div` of 0 or 1) behaves as 65536, which gives 32768 low cycles and 32768 released cycles.
- R3: `launch_stb` is a one-cycle pulse in the low half. It fires when the number of core cycles since the first cycle SCL is driven low equals the launch delay; a delay of 0 fires in that first low cycle.
- R4: `sample_stb` is a one-cycle pulse in the released half. It fires in the cycle where the number of cycles that `scl_in` has read high in this half equals the sample delay, and only while `scl_in` is high.
- R5: A launch or sample delay equal to or greater than half the effective divider acts as half minus one, so each strobe still fires once per half.
- R6: During the released half, a cycle with `scl_in` low does not advance the half. SCL stays released, and every later event moves back by the number of stretched cycles.
- R7: If `scl_in` stays low in the released half for `cfg_stretch_lim` times the effective divider core cycles, `stretch_timeout` rises in the next cycle. It stays high while `run` is high, and during that time SCL stays released and no strobe fires. A stretch of one cycle less than that raises nothing.
- R8: A `cfg_stretch_lim` of 0 disables the timeout, however long the stretch lasts.
- R9: When `run` reads low at a clock edge, the block returns to idle in the next cycle: SCL is released, `stretch_timeout` is low and no strobe fires. The cycle after `run` is first seen high, SCL is driven low, and a new period starts.
- R10: After reset, SCL is released and `launch_stb`, `sample_stb` and `stretch_timeout` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to generate clock periods; low aborts to idle |
| cfg_div | input | 16 | SCL period in core cycles; bit 0 ignored, 0 means 65536 |
| cfg_launch_dly | input | 16 | Core cycles from SCL fall to the launch strobe |
| cfg_sample_dly | input | 16 | High cycles from SCL seen high to the sample strobe |
| cfg_stretch_lim | input | 16 | Stretch limit in SCL periods; 0 disables |
| scl_in | input | 1 | Synchronised level of the SCL wire |
| scl_drive_low | output | 1 | High to pull SCL low, low to release it |
| launch_stb | output | 1 | One-cycle pulse: SDA may change now |
| sample_stb | output | 1 | One-cycle pulse: sample SDA now |
| stretch_timeout | output | 1 | Slave held SCL low too long |

## Verification
The bench builds the block with the default 16-bit counter width. At this width a divider of 0 gives a full 65536-cycle period, which fits inside one run and covers the wrap-to-maximum case. The same width also reaches the other extreme, a divider of 2 with halves of one cycle, where both strobes are clamped onto the first cycle of their half. A small divider together with a two-period stretch limit puts the timeout boundary (a stretch of one cycle less than the limit versus an unbounded stretch) within a few dozen cycles.

// File: rtl/sclt_pkg.sv
`timescale 1ns/1ps
package sclt_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_TMO  = 2'd3
    } phase_e;
endpackage

// File: rtl/sclt_cfg.sv
`timescale 1ns/1ps
// Derives half period and clamped strobe points from static configuration.
module sclt_cfg #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] div,
    input  logic [CNT_W-1:0] launch_dly,
    input  logic [CNT_W-1:0] sample_dly,
    output logic [CNT_W-1:0] half_m1,
    output logic [CNT_W-1:0] period_m1,
    output logic [CNT_W-1:0] launch_pt,
    output logic [CNT_W-1:0] sample_pt
);
    localparam logic [CNT_W-1:0] HALF_MAX = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] half;

    always_comb begin
        // bit 0 of the divider carries no weight; zero wraps to the maximum
        if (div[CNT_W-1:1] == '0) half = HALF_MAX;
        else                      half = {1'b0, div[CNT_W-1:1]};
        half_m1   = half - ONE;
        period_m1 = {half_m1[CNT_W-2:0], 1'b1};
        launch_pt = (launch_dly > half_m1) ? half_m1 : launch_dly;
        sample_pt = (sample_dly > half_m1) ? half_m1 : sample_dly;
    end
endmodule

// File: rtl/sclt_stretch.sv
`timescale 1ns/1ps
// Counts stretched core cycles in whole SCL periods and flags the limit.
module sclt_stretch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [CNT_W-1:0] period_m1,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] sub;
        logic [CNT_W-1:0] per;
    } str_t;

    str_t           st_d, st_q;
    logic [CNT_W:0] per_inc;

    always_comb begin
        st_d    = st_q;
        expire  = 1'b0;
        per_inc = {1'b0, st_q.per} + {1'b0, ONE};
        if (clr) begin
            st_d = '0;
        end else if (active) begin
            if (st_q.sub == period_m1) begin
                st_d.sub = '0;
                st_d.per = per_inc[CNT_W-1:0];
                if ((limit != '0) && (per_inc == {1'b0, limit})) expire = 1'b1;
            end else begin
                st_d.sub = st_q.sub + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sclt_phase.sv
`timescale 1ns/1ps
// Phase sequencer: idle, driven-low half, released half, timed-out.
module sclt_phase
    import sclt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic             expire,
    input  logic [CNT_W-1:0] half_m1,
    output phase_e           phase_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.phase)
            PH_IDLE: begin
                if (run) begin
                    sq_d.phase = PH_LOW;
                    sq_d.cnt   = '0;
                end
            end
            PH_LOW: begin
                if (sq_q.cnt == half_m1) begin
                    sq_d.phase = PH_HIGH;
                    sq_d.cnt   = '0;
                end else begin
                    sq_d.cnt = sq_q.cnt + ONE;
                end
            end
            PH_HIGH: begin
                if (expire) begin
                    sq_d.phase = PH_TMO;
                    sq_d.cnt   = '0;
                end else if (scl_in) begin
                    // the released half only advances once the wire reads high
                    if (sq_q.cnt == half_m1) begin
                        sq_d.phase = PH_LOW;
                        sq_d.cnt   = '0;
                    end else begin
                        sq_d.cnt = sq_q.cnt + ONE;
                    end
                end
            end
            PH_TMO: begin
                sq_d = sq_q;
            end
            default: begin
                sq_d.phase = PH_IDLE;
                sq_d.cnt   = '0;
            end
        endcase
        if (!run) begin
            sq_d.phase = PH_IDLE;
            sq_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{phase: PH_IDLE, cnt: '0};
        else        sq_q <= sq_d;
    end

    assign phase_q = sq_q.phase;
    assign cnt_q   = sq_q.cnt;
endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer
    import sclt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_launch_dly,
    input  logic [CNT_W-1:0] cfg_sample_dly,
    input  logic [CNT_W-1:0] cfg_stretch_lim,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             launch_stb,
    output logic             sample_stb,
    output logic             stretch_timeout
);
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] period_m1;
    logic [CNT_W-1:0] launch_pt;
    logic [CNT_W-1:0] sample_pt;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    phase_e           phase_q;

    sclt_cfg #(.CNT_W(CNT_W)) u_cfg (
        .div        (cfg_div),
        .launch_dly (cfg_launch_dly),
        .sample_dly (cfg_sample_dly),
        .half_m1    (half_m1),
        .period_m1  (period_m1),
        .launch_pt  (launch_pt),
        .sample_pt  (sample_pt)
    );

    sclt_stretch #(.CNT_W(CNT_W)) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (phase_q != PH_HIGH),
        .active    ((phase_q == PH_HIGH) && !scl_in),
        .period_m1 (period_m1),
        .limit     (cfg_stretch_lim),
        .expire    (expire)
    );

    sclt_phase #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .scl_in  (scl_in),
        .expire  (expire),
        .half_m1 (half_m1),
        .phase_q (phase_q),
        .cnt_q   (cnt_q)
    );

    always_comb begin
        scl_drive_low   = (phase_q == PH_LOW);
        launch_stb      = (phase_q == PH_LOW) && (cnt_q == launch_pt);
        sample_stb      = (phase_q == PH_HIGH) && scl_in && (cnt_q == sample_pt);
        stretch_timeout = (phase_q == PH_TMO);
    end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_timer_chk
    import sclt_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   run,
    input logic   scl_in,
    input logic   scl_drive_low,
    input logic   launch_stb,
    input logic   sample_stb,
    input logic   stretch_timeout,
    input phase_e phase
);
    // R3
    launch_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> scl_drive_low);
    // R3
    launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |=> !launch_stb);
    // R4
    sample_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (scl_in && !scl_drive_low));
    // R4
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_HIGH) && !scl_in) |=> !scl_drive_low);
    // R7
    tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_timeout |-> (!scl_drive_low && !launch_stb && !sample_stb));
    // R7
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_timeout && run) |=> stretch_timeout);
    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!scl_drive_low && !stretch_timeout));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .run             (run),
    .scl_in          (scl_in),
    .scl_drive_low   (scl_drive_low),
    .launch_stb      (launch_stb),
    .sample_stb      (sample_stb),
    .stretch_timeout (stretch_timeout),
    .phase           (phase_q)
);

// File: tb/tb_i2c_scl_timer.sv
`timescale 1ns/1ps
module tb_i2c_scl_timer;
    localparam int EV_FALL = 0, EV_LAUNCH = 1, EV_SAMPLE = 2, EV_TMO = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] cfg_div = 16'd8, cfg_launch_dly = '0, cfg_sample_dly = '0, cfg_stretch_lim = '0;
    logic        scl_in, scl_drive_low, launch_stb, sample_stb, stretch_timeout;

    logic hold = 1'b0;
    int   hold_len = 0;
    int   hold_left = 0;
    bit   hold_abort = 1'b0;

    assign scl_in = !scl_drive_low && !hold;

    i2c_scl_timer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_div(cfg_div),
        .cfg_launch_dly(cfg_launch_dly), .cfg_sample_dly(cfg_sample_dly),
        .cfg_stretch_lim(cfg_stretch_lim), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .launch_stb(launch_stb),
        .sample_stb(sample_stb), .stretch_timeout(stretch_timeout)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;
    ev_t   evq[$];
    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    function automatic void push_ev(int k, int at, string req);
        ev_t e;
        e.kind = k; e.at = at; e.req = req;
        evq.push_back(e);
    endfunction

    task automatic seen(int k);
        ev_t e;
        n_cmp++;
        if (evq.size() == 0) begin
            n_bad++;
            $display("FAIL %s: event kind %0d at cycle %0d, expected no event", cur_req, k, cyc);
        end else begin
            e = evq.pop_front();
            if (e.kind != k || e.at != cyc) begin
                n_bad++;
                $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                         e.req, k, cyc, e.kind, e.at);
            end
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drain();
        while (evq.size() > 0) begin
            ev_t e;
            e = evq.pop_front();
            n_cmp++;
            n_bad++;
            $display("FAIL %s: missing event kind %0d, expected at cycle %0d, actual none",
                     e.req, e.kind, e.at);
        end
    endtask

    // monitor and stretching slave model
    logic prev_low = 1'b0, prev_tmo = 1'b0;
    always @(negedge clk) begin
        if (hold_abort) begin
            hold = 1'b0;
            hold_left = 0;
        end else if (!scl_drive_low && prev_low && hold_len > 0) begin
            hold = 1'b1;
            hold_left = hold_len - 1;
        end else if (hold) begin
            if (hold_left > 0) hold_left--;
            else hold = 1'b0;
        end
        #1;
        if (rst_n) begin
            if (scl_drive_low && !prev_low) seen(EV_FALL);
            if (launch_stb) seen(EV_LAUNCH);
            if (sample_stb) seen(EV_SAMPLE);
            if (stretch_timeout && !prev_tmo) seen(EV_TMO);
        end
        prev_low = scl_drive_low;
        prev_tmo = stretch_timeout;
    end

    // driver: schedules expected events for n periods, then stops
    task automatic run_periods(input int div, input int fd, input int rd, input int lim,
                               input int n, input int stretch, input string req);
        int h, fe, re, s, per, base, end_c;
        h  = ((div >> 1) & 16'h7fff) == 0 ? 32768 : ((div >> 1) & 16'h7fff);
        fe = (fd >= h) ? h - 1 : fd;
        re = (rd >= h) ? h - 1 : rd;
        cfg_div = div[15:0]; cfg_launch_dly = fd[15:0]; cfg_sample_dly = rd[15:0];
        cfg_stretch_lim = lim[15:0];
        hold_len = stretch;
        cur_req = req;
        @(negedge clk);
        s = cyc + 1;
        run = 1'b1;
        per = 2 * h + stretch;
        for (int p = 0; p < n; p++) begin
            base = s + p * per;
            push_ev(EV_FALL, base, req);
            push_ev(EV_LAUNCH, base + fe, req);
            push_ev(EV_SAMPLE, base + h + stretch + re, req);
        end
        end_c = s + n * per - 1;
        while (cyc < end_c) @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        drain();
        hold_len = 0;
    endtask

    initial begin : main
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R10: reset state
        chk(scl_drive_low == 1'b0, "R10", "scl_drive_low", scl_drive_low, 0);
        chk(launch_stb == 1'b0, "R10", "launch_stb", launch_stb, 0);
        chk(sample_stb == 1'b0, "R10", "sample_stb", sample_stb, 0);
        chk(stretch_timeout == 1'b0, "R10", "stretch_timeout", stretch_timeout, 0);
        repeat (10) @(negedge clk);

        run_periods(8, 1, 2, 0, 3, 0, "R1");     // R1 basic period, R3/R4 strobes
        run_periods(9, 0, 0, 0, 2, 0, "R1");     // R1 LSB ignored, zero delays
        run_periods(10, 7, 5, 0, 2, 0, "R5");    // R5 both delays clamp to 4
        run_periods(2, 3, 0, 0, 3, 0, "R5");     // R5 one-cycle halves
        run_periods(8, 1, 2, 4, 2, 3, "R6");     // R6 stretch shifts events
        run_periods(8, 1, 0, 2, 2, 15, "R7");    // R7 one cycle short of limit
        run_periods(4, 0, 1, 0, 1, 200, "R8");   // R8 limit 0 disables

        // R7 timeout: divider 6 (half 3), limit 2 -> 12 stretched cycles
        cur_req = "R7";
        cfg_div = 16'd6; cfg_launch_dly = 16'd1; cfg_sample_dly = 16'd0; cfg_stretch_lim = 16'd2;
        hold_len = 1000000;
        @(negedge clk);
        s = cyc + 1;
        run = 1'b1;
        push_ev(EV_FALL, s, "R7");
        push_ev(EV_LAUNCH, s + 1, "R7");
        push_ev(EV_TMO, s + 3 + 12, "R7");
        while (cyc < s + 22) @(negedge clk);
        #2;
        chk(stretch_timeout == 1'b1, "R7", "stretch_timeout held", stretch_timeout, 1);
        chk(scl_drive_low == 1'b0, "R7", "scl_drive_low during timeout", scl_drive_low, 0);
        run = 1'b0;
        hold_abort = 1'b1;
        @(negedge clk); #2;
        cur_req = "R9";
        chk(stretch_timeout == 1'b0, "R9", "stretch_timeout after stop", stretch_timeout, 0);
        chk(scl_drive_low == 1'b0, "R9", "scl_drive_low after stop", scl_drive_low, 0);
        hold_abort = 1'b0;
        hold_len = 0;
        repeat (3) @(negedge clk);
        #2;
        drain();

        run_periods(12, 2, 3, 0, 2, 0, "R9");    // R9 restart after abort
        run_periods(0, 3, 100, 0, 1, 0, "R2");   // R2 divider 0 -> 65536

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL %s: watchdog at cycle %0d, expected completion earlier", cur_req, cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule